// File: doc/BRIEF.md
# GPIO Pin Interrupt Sensing Unit

This block watches a bank of general-purpose pins and turns their activity into interrupt events. For each pin, software picks level or edge sensing, which polarity counts as active, and whether edge sensing should fire on both transitions. A pin only takes part when its input enable is set and it is configured as an input. Every pin input passes through a two-flop synchronizer before any sensing happens.

Each pin has an event flag. In edge mode the flag latches a matching transition and stays set until software writes a 0 to that flag bit. In level mode the flag tracks the polarity-corrected pin level. A per-pin mask selects which flags drive the single combined interrupt line. Software reaches every setting through a small register bus. A write lands on the clock edge where `reg_we` is high, and reads are combinational from `reg_addr`. The bus has no back-pressure, so every access completes in one cycle.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, every register at addresses 0 to 6 reads 0, and `irq_o` is 0.
- R2: A pin senses only while its input-enable bit (address 1) is 1 and its direction bit (address 0, 1 = output) is 0. Otherwise its level-mode flag reads 0, and in edge mode no new flag is set.
- R3: A pin with mode bit (address 2) 0 and polarity bit (address 4) 0 has a flag equal to its pin level. The flag appears on the third rising clock edge after the pin changes.
- R4: A pin in level mode with polarity 1 has a flag equal to the inverted pin level.
- R5: A pin with mode bit 1, both-edges bit (address 3) 0 and polarity 0 sets its flag on a rising transition only. The flag is set on the third clock edge after the transition.
- R6: A pin in edge mode with polarity 1 and both-edges 0 sets its flag on a falling transition only.
- R7: A pin in edge mode with both-edges 1 sets its flag on either transition, whatever its polarity.
- R8: An edge-mode flag stays set until a write to address 6 carries 0 in that bit. A 1 in that bit leaves the flag unchanged.
- R9: Writes to address 6 have no effect on level-mode flags.
- R10: `irq_o` is the OR over all pins of (flag AND mask bit), with the mask at address 5.
- R11: When a matching edge and a clearing write to address 6 reach a flag on the same clock edge, the flag ends up set.
- R12: Addresses 0 to 5 read back the last value written. Address 7 reads the synchronized pin levels and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 16 | Asynchronous pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is a flag clear that lands on the same edge as a new matching transition. From the ports, this needs the pin change and the write strobe placed exactly two synchronizer cycles apart. The bench drives the pin, counts two rising edges, raises the clear write for the third edge, and then reads the flag back. The rest of the stimulus sweeps 48 arithmetic pin patterns across a bank where the low three bits of each pin's index pick one of eight sensing modes and three pins are disabled. Clears and mask changes are interleaved throughout.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_OUT_SEL  = 3'd0,
    REG_SENSE_ON = 3'd1,
    REG_EDGE_MD  = 3'd2,
    REG_ANY_EDGE = 3'd3,
    REG_INVERT   = 3'd4,
    REG_IRQ_EN   = 3'd5,
    REG_EVENTS   = 3'd6,
    REG_PIN_LVL  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  localparam int unsigned DEPTH = STAGES + 1;
  logic [W-1:0] chain_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) chain_q[k] <= '0;
    end else begin
      chain_q[0] <= raw_i;
      for (int k = 1; k < DEPTH; k++) chain_q[k] <= chain_q[k-1];
    end
  end

  assign cur_o  = chain_q[STAGES-1];
  assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      out_sel_o,
  output logic [W-1:0]      sense_on_o,
  output logic [W-1:0]      edge_md_o,
  output logic [W-1:0]      any_edge_o,
  output logic [W-1:0]      invert_o,
  output logic [W-1:0]      irq_en_o,
  output logic [W-1:0]      clr_o
);
  localparam int unsigned NCFG = 6;
  logic [W-1:0] cfg_q [NCFG];

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)                                    cfg_q[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(g))         cfg_q[g] <= wdata_i;
    end
  end

  assign out_sel_o  = cfg_q[REG_OUT_SEL];
  assign sense_on_o = cfg_q[REG_SENSE_ON];
  assign edge_md_o  = cfg_q[REG_EDGE_MD];
  assign any_edge_o = cfg_q[REG_ANY_EDGE];
  assign invert_o   = cfg_q[REG_INVERT];
  assign irq_en_o   = cfg_q[REG_IRQ_EN];

  // A zero bit in a write to the event register requests a clear
  assign clr_o = (we_i && addr_i == REG_EVENTS) ? ~wdata_i : '0;
endmodule

// File: rtl/gpio_sense_cell.sv
module gpio_sense_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic edge_md_i,
  input  logic any_edge_i,
  input  logic invert_i,
  input  logic cur_i,
  input  logic prev_i,
  input  logic clr_i,
  output logic flag_o
);
  logic rise, fall, hit;

  always_comb begin
    rise = cur_i & ~prev_i;
    fall = ~cur_i & prev_i;
    if (any_edge_i)     hit = rise | fall;
    else if (invert_i)  hit = fall;
    else                hit = rise;
    hit = hit & en_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          flag_o <= 1'b0;
    else if (!edge_md_i) flag_o <= en_i & (cur_i ^ invert_i);
    else                 flag_o <= hit | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      pin_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              irq_o
);
  logic [W-1:0] lvl_cur, lvl_prev;
  logic [W-1:0] out_sel_q, sense_on_q, edge_q, any_edge_q, invert_q, mask_q;
  logic [W-1:0] clr_vec, flag_q, sense_en;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(pin_i), .cur_o(lvl_cur), .prev_o(lvl_prev)
  );

  gpio_cfg_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .out_sel_o(out_sel_q), .sense_on_o(sense_on_q), .edge_md_o(edge_q),
    .any_edge_o(any_edge_q), .invert_o(invert_q), .irq_en_o(mask_q), .clr_o(clr_vec)
  );

  assign sense_en = sense_on_q & ~out_sel_q;

  for (genvar p = 0; p < W; p++) begin : g_pin
    gpio_sense_cell u_cell (
      .clk(clk), .rst_n(rst_n), .en_i(sense_en[p]), .edge_md_i(edge_q[p]),
      .any_edge_i(any_edge_q[p]), .invert_i(invert_q[p]), .cur_i(lvl_cur[p]),
      .prev_i(lvl_prev[p]), .clr_i(clr_vec[p]), .flag_o(flag_q[p])
    );
  end

  assign irq_o = |(flag_q & mask_q);

  always_comb begin
    case (reg_sel_e'(reg_addr))
      REG_OUT_SEL:  reg_rdata = out_sel_q;
      REG_SENSE_ON: reg_rdata = sense_on_q;
      REG_EDGE_MD:  reg_rdata = edge_q;
      REG_ANY_EDGE: reg_rdata = any_edge_q;
      REG_INVERT:   reg_rdata = invert_q;
      REG_IRQ_EN:   reg_rdata = mask_q;
      REG_EVENTS:   reg_rdata = flag_q;
      default:      reg_rdata = lvl_cur;
    endcase
  end
endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [W-1:0]      flag,
  input logic [W-1:0]      mask,
  input logic [W-1:0]      sense_en,
  input logic [W-1:0]      edge_md,
  input logic [W-1:0]      cur,
  input logic [W-1:0]      prev,
  input logic              irq
);
  // R2
  disabled_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~$past(flag) & ~$past(sense_en)) == '0));

  // R5
  edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~$past(flag) & $past(edge_md) & ~($past(cur) ^ $past(prev))) == '0));

  // R8
  edge_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag) & ~flag & $past(edge_md)) != '0) |->
      ($past(reg_we) && $past(reg_addr) == REG_EVENTS));

  // R10
  no_mask_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .flag(flag_q), .mask(mask_q), .sense_en(sense_en), .edge_md(edge_q),
  .cur(lvl_cur), .prev(lvl_prev), .irq(irq_o)
);

// File: tb/tb_gpio_irq_sense.sv
`timescale 1ns/1ps
module tb_gpio_irq_sense;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, irq_o;
  logic [W-1:0] pin_i = '0, reg_wdata = '0, reg_rdata;
  logic [2:0] reg_addr = '0;
  int checks = 0, errors = 0;

  logic [W-1:0] c_dir = 16'h2000, c_inen = 16'h3FFF, c_edge = 16'hAAAA;
  logic [W-1:0] c_both = 16'hCCCC, c_pol = 16'hF0F0, c_mask = '0;
  logic [W-1:0] ef = '0, oldp = '0;

  always #2.5 clk = ~clk;

  gpio_irq_sense dut (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic string pin_tag(input int i);
    if (!(c_inen[i] & ~c_dir[i])) return "R2";
    if (!c_edge[i]) return c_pol[i] ? "R4" : "R3";
    if (c_both[i]) return "R7";
    return c_pol[i] ? "R6" : "R5";
  endfunction

  // Reference model: apply a new stable pin value
  task automatic model(input logic [W-1:0] np);
    for (int i = 0; i < W; i++) begin
      logic en, r, f, h;
      en = c_inen[i] & ~c_dir[i];
      r = np[i] & ~oldp[i];
      f = ~np[i] & oldp[i];
      h = c_both[i] ? (r | f) : (c_pol[i] ? f : r);
      if (!c_edge[i]) ef[i] = en & (np[i] ^ c_pol[i]);
      else if (en & h) ef[i] = 1'b1;
    end
    oldp = np;
  endtask

  task automatic check_flags(input string ctx);
    logic [W-1:0] v;
    rd(3'd6, v);
    for (int i = 0; i < W; i++)
      chk($sformatf("%s pin%0d %s", pin_tag(i), i, ctx), W'(v[i]), W'(ef[i]));
    chk("R10 irq", W'(irq_o), W'(|(ef & c_mask)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 7; a++) begin rd(3'(a), v); chk("R1 reset reg", v, '0); end
    chk("R1 irq", W'(irq_o), '0);

    wr(3'd0, c_dir); wr(3'd1, c_inen); wr(3'd2, c_edge);
    wr(3'd3, c_both); wr(3'd4, c_pol); wr(3'd5, c_mask);
    // R12: readback
    rd(3'd0, v); chk("R12 dir", v, c_dir);
    rd(3'd1, v); chk("R12 inen", v, c_inen);
    rd(3'd2, v); chk("R12 edge", v, c_edge);
    rd(3'd3, v); chk("R12 both", v, c_both);
    rd(3'd4, v); chk("R12 pol", v, c_pol);
    rd(3'd5, v); chk("R12 mask", v, c_mask);
    wr(3'd7, 16'hFFFF);
    rd(3'd7, v); chk("R12 pin reg ignores write", v, '0);
    model(oldp);
    check_flags("after config");

    for (int s = 1; s <= 48; s++) begin
      logic [W-1:0] pat;
      pat = 16'(s * 40503) ^ 16'(s << 5);
      c_mask = (s % 11 == 0) ? '0 : 16'(s * 12061);
      wr(3'd5, c_mask);
      pin_i = pat;
      repeat (4) @(posedge clk);
      @(negedge clk);
      model(pat);
      check_flags("sweep");
      rd(3'd7, v); chk("R12 pin level", v, pat);
      if (s % 6 == 0) begin
        logic [W-1:0] wv;
        wv = (s % 12 == 0) ? '0 : 16'(s * 7919);
        wr(3'd6, wv);
        // R8 edge bits with 0 clear, R9 level bits unaffected
        ef = ef & ~(c_edge & ~wv);
        rd(3'd6, v);
        chk("R8 edge flags after write", v & c_edge, ef & c_edge);
        chk("R9 level flags after write", v & ~c_edge, ef & ~c_edge);
        chk("R10 irq after clear", W'(irq_o), W'(|(ef & c_mask)));
      end
    end

    // R11: edge and clear on the same clock edge (pin 1: rising edge mode)
    pin_i = '0;
    repeat (4) @(posedge clk); @(negedge clk);
    model('0);
    wr(3'd6, '0);
    ef = ef & ~c_edge;
    pin_i = 16'h0002;
    @(posedge clk); @(posedge clk); @(negedge clk);
    reg_addr = 3'd6; reg_wdata = '0; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
    rd(3'd6, v);
    chk("R11 edge wins over clear", W'(v[1]), W'(1'b1));
    chk("R11 other edge flags cleared", v & c_edge & ~16'h0002, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule